// File: doc/BRIEF.md
# Dual-Speed Processor Clock Stretcher

This block derives all processor-side timing from one fast master clock. A counter chain divides the master clock into single-cycle phase enables at one half, one quarter and one eighth of the master rate. With a 16 MHz master clock these are 8, 4 and 2 MHz. A toggle flop driven by the slowest phase enable yields a free-running square wave at half that rate, the 1 MHz peripheral clock. Because it is built from the 2 MHz enable, it is always phase-locked to it.

The processor advances on a clock enable that normally pulses with every 2 MHz phase. Memory accesses therefore complete in one short cycle. When the address decoder marks the current access as belonging to a slow peripheral, it drives an active-low request. The block samples that request once per processor cycle and latches it. It then suppresses one or two processor enable pulses, so that the stretched access ends exactly when the 1 MHz peripheral clock rises. After that it clears the latch and returns to full speed.

The block is placed next to the address decoder. Its enables feed the processor core, the memory sequencer and the slow peripherals.

Top module: `cpu_clock_stretcher`

## Requirements
- R1: While `rst_n` is low, `cpu_en`, `clk1m` and every bit of `phase_en` are 0. After `rst_n` rises, the first `cpu_en` pulse comes in the 7th master cycle, and `clk1m` is high from the 8th master cycle on.
- R2: `phase_en[k]` is high for one master cycle in every 2^(k+1). Bit 0 runs at half the master rate and the top bit is the processor-rate (2 MHz) enable. Whenever a slower bit pulses, every faster bit pulses in the same cycle.
- R3: `clk1m` changes level only in the master cycle right after a top-bit `phase_en` pulse. It is therefore a square wave that stays 8 master cycles high and 8 low at default parameters.
- R4: With no request, `cpu_en` pulses exactly with the top bit of `phase_en`, giving a processor cycle of 8 master cycles.
- R5: `slow_req_n` is active low. It is sampled only in the mid-cycle master cycle, where `phase_en[1]` is high and `phase_en[2]` is low. A low level at any other time has no effect on `cpu_en`.
- R6: A latched request suppresses `cpu_en` at the next processor boundary and at every following boundary until one where `clk1m` is low, that is, one just before `clk1m` rises. `cpu_en` fires there. The stretched cycle is 16 master cycles (one pulse suppressed) or 24 (two suppressed), depending on alignment.
- R7: No processor cycle is shorter than 8 master cycles, and never more than two consecutive boundaries are suppressed.
- R8: A low `slow_req_n` at a sample point during a stretch is ignored. The latch is empty after the release, so the following cycle runs at full speed unless a fresh request is sampled within it.
- R9: Slow accesses issued back to back each receive their own stretch, each ending at its own `clk1m` rising boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (16 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_req_n | input | 1 | Active-low slow-peripheral access flag from the address decoder |
| cpu_en | output | 1 | Processor clock enable, one master cycle wide at each processor cycle end |
| clk1m | output | 1 | Free-running peripheral clock at one sixteenth of the master rate |
| phase_en | output | DIV_LOG2-1 | Phase enables at 1/2, 1/4, 1/8 of master rate (bit 0 fastest) |

## Verification
The hardest case to reach is the long stretch, where the request is latched just before a processor boundary at which `clk1m` is about to rise. The block must then let that rising edge pass and hold the processor through a second suppressed boundary. A close second is a request level that falls on a sample point while a stretch is already running. The stimulus watches `phase_en` and `clk1m` to find a boundary of the wanted polarity. From there it drives `slow_req_n` through a 48-cycle bit pattern indexed by master cycles, so a low level lands on a chosen sample point, or deliberately misses all of them. It then measures the distances between successive `cpu_en` pulses and the `clk1m` level at each release.

// File: rtl/cpu_clkstr_pkg.sv
package cpu_clkstr_pkg;

   // Mask controller state: running at full speed, or holding a stretch
   typedef enum logic {
      MSK_RUN  = 1'b0,
      MSK_HOLD = 1'b1
   } mask_state_t;

   // Smallest legal divider depth: fast, mid and processor phases
   localparam int unsigned MIN_DIV_LOG2 = 3;

endpackage

// File: rtl/cpu_clkstr_div.sv
module cpu_clkstr_div #(
   parameter int unsigned DIV_LOG2 = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [DIV_LOG2-2:0] phase_en,
   output logic                sample_stb,
   output logic                clk_slow,
   output logic                rise_next
);
   localparam int unsigned NPH = DIV_LOG2 - 1;

   logic [NPH-1:0] cnt_q;
   logic           slow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   // One pulse per power-of-two period, all aligned to the counter wrap
   for (genvar k = 0; k < NPH; k++) begin : g_phase
      assign phase_en[k] = &cnt_q[k:0];
   end

   // Toggle flop clocked by the processor-rate enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               slow_q <= 1'b0;
      else if (phase_en[NPH-1]) slow_q <= ~slow_q;
   end

   assign clk_slow   = slow_q;
   assign sample_stb = phase_en[NPH-2] & ~phase_en[NPH-1];
   assign rise_next  = phase_en[NPH-1] & ~slow_q;

endmodule

// File: rtl/cpu_clkstr_req.sv
module cpu_clkstr_req (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_req_n,
   input  logic sample_stb,
   input  logic accept,
   input  logic clear,
   output logic pending
);
   logic slow_req;
   logic pend_q;

   assign slow_req = ~slow_req_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 pend_q <= 1'b0;
      else if (clear)                             pend_q <= 1'b0;
      else if (sample_stb && accept && slow_req)  pend_q <= 1'b1;
   end

   assign pending = pend_q;

endmodule

// File: rtl/cpu_clkstr_mask.sv
module cpu_clkstr_mask
   import cpu_clkstr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rise_next,
   input  logic pending,
   output logic cpu_en,
   output logic release_req,
   output logic stretching
);
   mask_state_t state_q, state_d;
   logic        hold;
   logic        fire_slow;

   // First boundary of a slow access is always suppressed; later ones
   // are suppressed until the peripheral clock is about to rise.
   assign hold      = tick & pending & ((state_q == MSK_RUN) | ~rise_next);
   assign fire_slow = tick & pending & (state_q == MSK_HOLD) & rise_next;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MSK_RUN:  if (tick && pending) state_d = MSK_HOLD;
         MSK_HOLD: if (fire_slow)       state_d = MSK_RUN;
         default:                       state_d = MSK_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= MSK_RUN;
      else        state_q <= state_d;
   end

   assign cpu_en      = tick & ~hold;
   assign release_req = fire_slow;
   assign stretching  = (state_q == MSK_HOLD);

endmodule

// File: rtl/cpu_clock_stretcher.sv
module cpu_clock_stretcher
   import cpu_clkstr_pkg::*;
#(
   parameter int unsigned DIV_LOG2 = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slow_req_n,
   output logic                cpu_en,
   output logic                clk1m,
   output logic [DIV_LOG2-2:0] phase_en
);
   localparam int unsigned NPH = DIV_LOG2 - 1;

   initial begin
      assert (DIV_LOG2 >= MIN_DIV_LOG2)
         else $error("DIV_LOG2 must be at least %0d", MIN_DIV_LOG2);
   end

   logic [NPH-1:0] ph;
   logic           sample_stb;
   logic           clk_slow;
   logic           rise_next;
   logic           pending;
   logic           release_req;
   logic           stretching;

   cpu_clkstr_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_en   (ph),
      .sample_stb (sample_stb),
      .clk_slow   (clk_slow),
      .rise_next  (rise_next)
   );

   cpu_clkstr_req u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_req_n (slow_req_n),
      .sample_stb (sample_stb),
      .accept     (~stretching),
      .clear      (release_req),
      .pending    (pending)
   );

   cpu_clkstr_mask u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (ph[NPH-1]),
      .rise_next   (rise_next),
      .pending     (pending),
      .cpu_en      (cpu_en),
      .release_req (release_req),
      .stretching  (stretching)
   );

   assign phase_en = ph;
   assign clk1m    = clk_slow;

endmodule

// File: rtl/cpu_clock_stretcher_chk.sv
module cpu_clock_stretcher_chk #(
   parameter int unsigned DIV_LOG2 = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_en,
   input logic                clk1m,
   input logic [DIV_LOG2-2:0] phase_en
);
   localparam int unsigned NPH = DIV_LOG2 - 1;
   localparam int unsigned PER = 2 ** NPH;
   localparam int unsigned GW  = $clog2(4 * PER) + 1;

   logic [GW-1:0] gap_q;
   logic          seen_q;
   logic [1:0]    masks_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q   <= '0;
         seen_q  <= 1'b0;
         masks_q <= '0;
      end else begin
         if (cpu_en)            gap_q <= GW'(1);
         else if (~&gap_q)      gap_q <= gap_q + 1'b1;
         if (cpu_en)            seen_q <= 1'b1;
         if (cpu_en)            masks_q <= '0;
         else if (phase_en[NPH-1] && masks_q != 2'd3) masks_q <= masks_q + 1'b1;
      end
   end

   assert_en_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_en |-> phase_en[NPH-1]);

   assert_min_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en && seen_q) |-> (gap_q >= GW'(PER)));

   assert_mask_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      masks_q <= 2'd2);

   assert_release_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en && masks_q != 2'd0) |-> !clk1m);

   assert_slow_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk1m) |-> $past(phase_en[NPH-1]));

   for (genvar k = 1; k < NPH; k++) begin : g_nest
      assert_phase_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
         phase_en[k] |-> phase_en[k-1]);
   end

endmodule

bind cpu_clock_stretcher cpu_clock_stretcher_chk #(.DIV_LOG2(DIV_LOG2)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_en   (cpu_en),
   .clk1m    (clk1m),
   .phase_en (phase_en)
);

// File: tb/tb_cpu_clock_stretcher.sv
module tb_cpu_clock_stretcher;
   localparam int DIV_LOG2 = 4;
   localparam int NPH      = DIV_LOG2 - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           slow_req_n = 1'b1;
   logic           cpu_en;
   logic           clk1m;
   logic [NPH-1:0] phase_en;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   cpu_clock_stretcher #(.DIV_LOG2(DIV_LOG2)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_req_n (slow_req_n),
      .cpu_en     (cpu_en),
      .clk1m      (clk1m),
      .phase_en   (phase_en)
   );

   task automatic check(input string tag, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // R1: reset values and first enable position
   task automatic test_reset;
      int first_en = -1;
      int first_hi = -1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", int'({cpu_en, clk1m, phase_en}), 0, "outputs during reset");
      rst_n = 1'b1;
      for (int n = 1; n <= 12; n++) begin
         @(negedge clk);
         if (cpu_en && first_en < 0) first_en = n;
         if (clk1m && first_hi < 0)  first_hi = n;
      end
      check("R1", first_en, 7, "first cpu_en cycle");
      check("R1", first_hi, 8, "first clk1m high cycle");
   endtask

   // R2, R3: phase enable rates, nesting, peripheral clock shape
   task automatic test_phases;
      int c0 = 0, c1 = 0, c2 = 0, hi = 0, rises = 0, nest_bad = 0, edge_bad = 0;
      logic prev_clk1m, prev_ph2;
      @(negedge clk);
      prev_clk1m = clk1m;
      prev_ph2   = phase_en[2];
      for (int n = 0; n < 32; n++) begin
         @(negedge clk);
         c0 += int'(phase_en[0]);
         c1 += int'(phase_en[1]);
         c2 += int'(phase_en[2]);
         hi += int'(clk1m);
         if (phase_en[2] && !phase_en[1]) nest_bad++;
         if (phase_en[1] && !phase_en[0]) nest_bad++;
         if (clk1m != prev_clk1m && !prev_ph2) edge_bad++;
         if (clk1m && !prev_clk1m) rises++;
         prev_clk1m = clk1m;
         prev_ph2   = phase_en[2];
      end
      check("R2", c0, 16, "phase_en[0] pulses in 32");
      check("R2", c1, 8,  "phase_en[1] pulses in 32");
      check("R2", c2, 4,  "phase_en[2] pulses in 32");
      check("R2", nest_bad, 0, "nesting violations");
      check("R3", hi, 16, "clk1m high cycles in 32");
      check("R3", rises, 2, "clk1m rising edges in 32");
      check("R3", edge_bad, 0, "clk1m edges not after 2MHz pulse");
   endtask

   // Align to a full-speed boundary (clk1m level given by rise_align:
   // 1 = boundary just before clk1m falls), drive the low-request
   // pattern indexed by master cycle, and measure two processor cycles.
   task automatic run_seq(input string tag, input logic [47:0] lowmask, input bit rise_align,
                          input int exp1, input int exp2);
      int gaps[2];
      int lvl[2];
      int idx = 0;
      int last = 0;
      do @(negedge clk);
      while (!(cpu_en && (clk1m == rise_align)));
      slow_req_n = ~lowmask[0];
      for (int i = 1; i < 64 && idx < 2; i++) begin
         @(negedge clk);
         if (cpu_en) begin
            gaps[idx] = i - last;
            lvl[idx]  = int'(clk1m);
            last      = i;
            idx++;
         end
         slow_req_n = (i < 48) ? ~lowmask[i] : 1'b1;
      end
      slow_req_n = 1'b1;
      check(tag, (idx > 0) ? gaps[0] : -1, exp1, "first cycle length");
      check(tag, (idx > 1) ? gaps[1] : -1, exp2, "second cycle length");
      if (exp1 > 8) check("R6", lvl[0], 0, "clk1m level at stretched release");
      if (exp2 > 8) check("R6", lvl[1], 0, "clk1m level at second release");
   endtask

   task automatic test_fast;           // R4
      run_seq("R4", 48'h0, 1'b0, 8, 8);
      run_seq("R4", 48'h0, 1'b1, 8, 8);
   endtask

   task automatic test_slow_short;     // R6: request sampled before a falling boundary
      run_seq("R6", 48'h0000_0000_00FF, 1'b0, 16, 8);
   endtask

   task automatic test_slow_long;      // R6: request sampled before a rising boundary
      run_seq("R6", 48'h0000_0000_00FF, 1'b1, 24, 8);
   endtask

   task automatic test_off_sample;     // R5: low everywhere except the sample points
      run_seq("R5", 48'h0000_0000_EFEF & ~48'h1010, 1'b0, 8, 8);
   endtask

   task automatic test_during_stretch; // R8: extra sample-point lows inside a stretch
      run_seq("R8", (48'h1 << 4) | (48'h1 << 12) | (48'h1 << 20), 1'b1, 24, 8);
   endtask

   task automatic test_back_to_back;   // R9 (with R7 minimum length implied)
      run_seq("R9", 48'h0000_FFFF_FFFF, 1'b0, 16, 16);
      run_seq("R9", 48'hFFFF_FFFF_FFFF, 1'b1, 24, 16);
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL R7 watchdog expired: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      test_reset();
      test_phases();
      test_fast();
      test_slow_short();
      test_slow_long();
      test_off_sample();
      test_during_stretch();
      test_back_to_back();
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule